// File: doc/BRIEF.md
# Interleaved Half-Rate Pseudorandom Vector Source

This block supplies a fresh pseudorandom test vector to an n-input logic cone on every cycle of one master clock, with fewer input transitions than a single n-stage generator. Two independent shift-register generators of n/2 stages each, both with primitive feedback, hold the vector between them. Their cells alternate across the output bits. On enabled cycles the two take turns: one shifts while the other holds its state. At most half of the output bits can therefore change in any cycle.

The alternation comes from a one-bit phase register on the master clock. That register produces two complementary advance enables, so there is no divided or gated clock. A seed load writes both halves at once and sets the phase so that the first half moves next. An all-zero seed is replaced by the value 1 so that neither half can lock up. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `lfsr_il_gen`

## Requirements
- R1: Bit order of `test_vec`. Bit 2j+1 holds cell j of the first half (A) and bit 2j holds cell j of the second half (B), for j = 0 to n/2-1.
- R2: During reset and after its release, each half holds the state 1. `test_vec` then reads 3 (only bits 1 and 0 set), and half A is the next to advance.
- R3: When `seed_load` is high at a clock edge, A takes `seed_a` and B takes `seed_b`. The next enabled cycle advances A. `seed_load` takes priority over `enable`.
- R4: A seed field of all zeros is loaded as the value 1. Neither half ever holds zero.
- R5: An advancing half with m stages and state s takes the state {f, s[m-1:1]}. Here f is the XOR of s[m-t] over its tap set t. For m=3 the taps are {3,2} and for m=4 they are {4,3}, so in both cases f = s[0]^s[1].
- R6: Cycles with `enable` high and `seed_load` low advance A, B, A, B and so on. Each such cycle advances exactly one half, and the other half keeps its state.
- R7: Outside a seed-load cycle, at most n/2 bits of `test_vec` change from one cycle to the next.
- R8: With `enable` low and `seed_load` low, both states and the phase hold. After such a pause, the alternation resumes with the half that was due next.
- R9: Each half returns to its seed after exactly 2^(n/2)-1 of its own advance steps, and not before.
- R10: For n=6 with both seeds equal to 001, the first enabled cycle gives `test_vec` = 100001 and the second gives 110000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| enable | input | 1 | Advances one half per cycle when high |
| seed_load | input | 1 | Loads both seeds and restarts the phase at half A |
| seed_a | input | WIDTH/2 | Seed for half A (odd output bits) |
| seed_b | input | WIDTH/2 | Seed for half B (even output bits) |
| test_vec | output | WIDTH | Interleaved test vector |

## Verification
The bench builds two copies of the block, one at the default width of 8 and one at width 6, and drives them with the same controls. The width-6 copy uses three-stage halves, which makes the worked vectors 100001 and 110000 directly checkable. The width-8 copy has four-stage halves with a period of 15, so a complete cycle of each half fits into about thirty clocks. Random enable pauses, seed loads and zero seeds are run on both copies against a behavioural model.

// File: rtl/lfsr_il_pkg.sv
package lfsr_il_pkg;

  typedef enum logic {
    PH_A = 1'b0,
    PH_B = 1'b1
  } phase_e;

  // Feedback mask for an m-stage right-shifting register whose new bit
  // enters at the top. Mask bit (m - t) is set for every tap t.
  function automatic logic [15:0] tap_mask(input int unsigned m);
    logic [15:0] r;
    case (m)
      2:       r = 16'h0003;
      3:       r = 16'h0003;
      4:       r = 16'h0003;
      5:       r = 16'h0005;
      6:       r = 16'h0003;
      7:       r = 16'h0003;
      8:       r = 16'h001D;
      9:       r = 16'h0011;
      10:      r = 16'h0009;
      11:      r = 16'h0005;
      12:      r = 16'h0941;
      13:      r = 16'h1601;
      14:      r = 16'h2A01;
      15:      r = 16'h0003;
      16:      r = 16'h100B;
      default: r = 16'h0003;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lfsr_il_phase.sv
module lfsr_il_phase
  import lfsr_il_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic seed_load,
  output logic adv_a,
  output logic adv_b
);

  phase_e ph_q;
  phase_e ph_d;
  logic   run;

  assign run = enable & ~seed_load;

  always_comb begin
    ph_d = ph_q;
    if (seed_load) begin
      ph_d = PH_A;
    end else if (enable) begin
      ph_d = (ph_q == PH_A) ? PH_B : PH_A;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_A;
    end else if (seed_load | enable) begin
      ph_q <= ph_d;
    end
  end

  assign adv_a = run & (ph_q == PH_A);
  assign adv_b = run & (ph_q == PH_B);

endmodule

// File: rtl/lfsr_il_half.sv
module lfsr_il_half
  import lfsr_il_pkg::*;
#(
  parameter int unsigned STAGES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [STAGES-1:0] seed,
  input  logic              step,
  output logic [STAGES-1:0] state
);

  localparam logic [15:0]       FULL_MASK = tap_mask(STAGES);
  localparam logic [STAGES-1:0] TAPS      = FULL_MASK[STAGES-1:0];
  localparam logic [STAGES-1:0] ONE       = STAGES'(1);

  logic [STAGES-1:0] st_q;
  logic [STAGES-1:0] st_d;
  logic [STAGES-1:0] seed_safe;
  logic              fb;

  assign seed_safe = (seed == '0) ? ONE : seed;
  assign fb        = ^(st_q & TAPS);

  always_comb begin
    st_d = st_q;
    if (load) begin
      st_d = seed_safe;
    end else if (step) begin
      st_d = {fb, st_q[STAGES-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ONE;
    end else if (load | step) begin
      st_q <= st_d;
    end
  end

  assign state = st_q;

endmodule

// File: rtl/lfsr_il_weave.sv
module lfsr_il_weave #(
  parameter int unsigned HALF = 4
) (
  input  logic [HALF-1:0]   half_a,
  input  logic [HALF-1:0]   half_b,
  output logic [2*HALF-1:0] vec
);

  for (genvar j = 0; j < HALF; j++) begin : g_bit
    assign vec[2*j+1] = half_a[j];
    assign vec[2*j]   = half_b[j];
  end

endmodule

// File: rtl/lfsr_il_gen.sv
module lfsr_il_gen #(
  parameter  int unsigned WIDTH = 8,
  localparam int unsigned HALF  = WIDTH / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             seed_load,
  input  logic [HALF-1:0]  seed_a,
  input  logic [HALF-1:0]  seed_b,
  output logic [WIDTH-1:0] test_vec
);

  localparam int unsigned NHALF = 2;

  logic                      rst_meta;
  logic                      rst_sync;
  logic                      adv_a;
  logic                      adv_b;
  logic [NHALF-1:0]          step_v;
  logic [NHALF-1:0][HALF-1:0] seed_v;
  logic [NHALF-1:0][HALF-1:0] state_v;
  logic [HALF-1:0]           st_a;
  logic [HALF-1:0]           st_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  lfsr_il_phase u_phase (
    .clk       (clk),
    .rst_n     (rst_sync),
    .enable    (enable),
    .seed_load (seed_load),
    .adv_a     (adv_a),
    .adv_b     (adv_b)
  );

  assign step_v = {adv_b, adv_a};
  assign seed_v = {seed_b, seed_a};

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    lfsr_il_half #(
      .STAGES (HALF)
    ) u_half (
      .clk   (clk),
      .rst_n (rst_sync),
      .load  (seed_load),
      .seed  (seed_v[h]),
      .step  (step_v[h]),
      .state (state_v[h])
    );
  end

  assign st_a = state_v[0];
  assign st_b = state_v[1];

  lfsr_il_weave #(
    .HALF (HALF)
  ) u_weave (
    .half_a (st_a),
    .half_b (st_b),
    .vec    (test_vec)
  );

endmodule

// File: rtl/lfsr_il_gen_chk.sv
module lfsr_il_gen_chk #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned HALF  = WIDTH / 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             seed_load,
  input logic [HALF-1:0]  seed_a,
  input logic [HALF-1:0]  seed_b,
  input logic [WIDTH-1:0] test_vec,
  input logic [HALF-1:0]  st_a,
  input logic [HALF-1:0]  st_b,
  input logic             adv_a,
  input logic             adv_b
);

  localparam logic [HALF-1:0] ONE = HALF'(1);

  // R3, R4: seeds land, with zero replaced by one
  a_r3_seed_a: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> st_a == (($past(seed_a) == '0) ? ONE : $past(seed_a)));
  a_r3_seed_b: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> st_b == (($past(seed_b) == '0) ? ONE : $past(seed_b)));

  // R4: no half ever reaches the all-zero state
  a_r4_no_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (st_a != '0) && (st_b != '0));

  // R6: one half per enabled cycle, and the same half never twice in a row
  a_r6_one_half: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !seed_load) |-> $onehot0({adv_a, adv_b}) && (adv_a || adv_b));
  a_r6_alt_a: assert property (@(posedge clk) disable iff (!rst_n)
    adv_a |=> !adv_a);
  a_r6_alt_b: assert property (@(posedge clk) disable iff (!rst_n)
    adv_b |=> !adv_b);
  a_r6_b_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_a && !seed_load) |=> $stable(st_b));

  // R7: limited output activity outside loads
  a_r7_half_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    !seed_load |=> $countones(test_vec ^ $past(test_vec)) <= HALF);

  // R8: idle cycles change nothing
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !seed_load) |=> $stable(test_vec));

endmodule

bind lfsr_il_gen lfsr_il_gen_chk #(
  .WIDTH (WIDTH),
  .HALF  (WIDTH / 2)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync),
  .enable    (enable),
  .seed_load (seed_load),
  .seed_a    (seed_a),
  .seed_b    (seed_b),
  .test_vec  (test_vec),
  .st_a      (st_a),
  .st_b      (st_b),
  .adv_a     (adv_a),
  .adv_b     (adv_b)
);

// File: tb/lfsr_il_gen_tb_top.sv
`timescale 1ns/1ps
module lfsr_il_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic       ld;
  logic [3:0] sa8, sb8;
  logic [2:0] sa6, sb6;
  logic [7:0] v8;
  logic [5:0] v6;

  always #5 clk = ~clk;

  lfsr_il_gen #(.WIDTH(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(en), .seed_load(ld),
    .seed_a(sa8), .seed_b(sb8), .test_vec(v8)
  );

  lfsr_il_gen #(.WIDTH(6)) dut_w6_i (
    .clk(clk), .rst_n(rst_n), .enable(en), .seed_load(ld),
    .seed_a(sa6), .seed_b(sb6), .test_vec(v6)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;

  // behavioural reference
  int ma8, mb8, ma6, mb6;
  bit ph;
  bit ld_seen;
  int prev8, prev6;

  function automatic int stepm(int s, int m);
    return (((s ^ (s >> 1)) & 1) << (m - 1)) | (s >> 1);
  endfunction

  function automatic int weave(int a, int b, int m);
    int r = 0;
    for (int j = 0; j < m; j++) begin
      r |= ((a >> j) & 1) << (2 * j + 1);
      r |= ((b >> j) & 1) << (2 * j);
    end
    return r;
  endfunction

  function automatic int oddf(int v, int m);
    int r = 0;
    for (int j = 0; j < m; j++) r |= ((v >> (2 * j + 1)) & 1) << j;
    return r;
  endfunction

  function automatic int evenf(int v, int m);
    int r = 0;
    for (int j = 0; j < m; j++) r |= ((v >> (2 * j)) & 1) << j;
    return r;
  endfunction

  function automatic int nz(int s);
    return (s == 0) ? 1 : s;
  endfunction

  function automatic int ones(int v);
    int c = 0;
    for (int j = 0; j < 32; j++) c += (v >> j) & 1;
    return c;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ma8 = 1; mb8 = 1; ma6 = 1; mb6 = 1; ph = 1'b0; ld_seen = 1'b0;
    end else begin
      ld_seen = ld;
      if (ld) begin
        ma8 = nz(int'(sa8)); mb8 = nz(int'(sb8));
        ma6 = nz(int'(sa6)); mb6 = nz(int'(sb6));
        ph  = 1'b0;
      end else if (en) begin
        if (!ph) begin
          ma8 = stepm(ma8, 4); ma6 = stepm(ma6, 3);
        end else begin
          mb8 = stepm(mb8, 4); mb6 = stepm(mb6, 3);
        end
        ph = ~ph;
      end
    end
  end

  // R1 R5 R6 compared every cycle; R7 activity bound
  always @(negedge clk) begin
    if (cmp_on) begin
      check(int'(v8) == weave(ma8, mb8, 4), "R1/R5/R6 w8 vector", int'(v8), weave(ma8, mb8, 4));
      check(int'(v6) == weave(ma6, mb6, 3), "R1/R5/R6 w6 vector", int'(v6), weave(ma6, mb6, 3));
      if (!ld_seen) begin
        check(ones(int'(v8) ^ prev8) <= 4, "R7 w8 toggles", ones(int'(v8) ^ prev8), 4);
        check(ones(int'(v6) ^ prev6) <= 3, "R7 w6 toggles", ones(int'(v6) ^ prev6), 3);
      end
    end
    prev8 = int'(v8);
    prev6 = int'(v6);
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    int lcg;
    int held;
    int a_before;
    int per_a;
    int per_b;
    rst_n = 1'b0; en = 1'b0; ld = 1'b0;
    sa8 = '0; sb8 = '0; sa6 = '0; sb6 = '0;
    repeat (3) @(negedge clk);
    check(v8 == 8'h03, "R2 reset w8", int'(v8), 3);
    check(v6 == 6'h03, "R2 reset w6", int'(v6), 3);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(v8 == 8'h03, "R2 after release w8", int'(v8), 3);
    cmp_on = 1'b1;

    // R10 worked example, load given priority over enable (R3)
    ld = 1'b1; en = 1'b1; sa6 = 3'b001; sb6 = 3'b001; sa8 = 4'd1; sb8 = 4'd1;
    @(negedge clk);
    ld = 1'b0;
    @(negedge clk);
    check(v6 == 6'b100001, "R10 first vector", int'(v6), 6'b100001);
    @(negedge clk);
    check(v6 == 6'b110000, "R10 second vector", int'(v6), 6'b110000);

    // R4 zero seeds
    en = 1'b0; ld = 1'b1; sa6 = '0; sb6 = '0; sa8 = '0; sb8 = '0;
    @(negedge clk);
    ld = 1'b0;
    check(v8 == 8'h03, "R4 zero seed w8", int'(v8), 3);
    check(v6 == 6'h03, "R4 zero seed w6", int'(v6), 3);

    // R8 pause with half B due next
    ld = 1'b1; sa8 = 4'd6; sb8 = 4'd11; sa6 = 3'd5; sb6 = 3'd2;
    @(negedge clk);
    ld = 1'b0; en = 1'b1;
    @(negedge clk);
    en = 1'b0;
    held = int'(v8);
    a_before = oddf(int'(v8), 4);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(int'(v8) == held, "R8 hold w8", int'(v8), held);
    end
    en = 1'b1;
    @(negedge clk);
    en = 1'b0;
    check(oddf(int'(v8), 4) == a_before, "R8 A kept after pause", oddf(int'(v8), 4), a_before);
    check(evenf(int'(v8), 4) == stepm(evenf(held, 4), 4), "R8 B resumes",
          evenf(int'(v8), 4), stepm(evenf(held, 4), 4));

    // random controls against the model
    lcg = 32'h1234_5678;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      lcg = lcg * 1103515245 + 12345;
      en  = ((lcg >> 16) & 3) != 0;
      ld  = ((lcg >> 20) & 15) == 0;
      sa8 = 4'((lcg >> 8)); sb8 = 4'((lcg >> 12));
      sa6 = 3'((lcg >> 24)); sb6 = 3'((lcg >> 27));
      if (((lcg >> 5) & 7) == 0) begin
        sa8 = '0; sb6 = '0;
      end
    end

    // R9 period of each half in its own steps (w8, 4 stages)
    @(negedge clk);
    ld = 1'b1; en = 1'b1; sa8 = 4'd5; sb8 = 4'd9;
    @(negedge clk);
    ld = 1'b0;
    per_a = 0; per_b = 0;
    for (int i = 1; i <= 32; i++) begin
      @(negedge clk);
      if ((i % 2) == 1 && per_a == 0 && oddf(int'(v8), 4) == 5) per_a = (i + 1) / 2;
      if ((i % 2) == 0 && per_b == 0 && evenf(int'(v8), 4) == 9) per_b = i / 2;
    end
    check(per_a == 15, "R9 period A", per_a, 15);
    check(per_b == 15, "R9 period B", per_b, 15);

    en = 1'b0;
    @(negedge clk);
    cmp_on = 1'b0;
    summary();
    $finish;
  end

endmodule